// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It divides the oscillator clock by four to get a counting clock. On that counting clock it runs a fixed-length measurement cycle of three phases: an offset-nulling phase, a fixed-time integration of the input, and a timed run-down against a reference. It drives one enable per phase to the analog switches. It also drives a select line that picks the reference sign, so that the run-down brings the integrator back toward zero.

The run-down time is measured in decade counters. The run-down stops when the synchronised comparator flips. The elapsed count is then captured as a 3½-digit BCD value, together with the sign of the input and a flag for a run-down that hit full scale. A one-cycle strobe marks each new result. The null phase absorbs whatever run-down time went unused, so every cycle takes the same number of counts whatever the input. With the default parameters that is 1000 + 2000 + 1000 = 4000 counts, or 16,000 oscillator clocks.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is low at a clock edge, the block enters the null phase (`ph_az`=1, the others 0), clears `ref_down`, `rd_valid`, `rd_bcd`, `rd_neg` and `rd_ovr`, and clears all of its counters.
- R2: Exactly one of `ph_az`, `ph_int` and `ph_dei` is high in every cycle after reset.
- R3: The phases run in the order null, integrate, run-down, null. Every phase boundary falls on a counting-clock edge, and counting-clock edges come every DIV oscillator clocks, so every phase length is a multiple of DIV clocks.
- R4: The integrate phase lasts exactly INT_CNT counts (INT_CNT·DIV clocks).
- R5: At the end of integration, `ref_down` takes the synchronised comparator value and holds it through the run-down. 1 applies the reference that drives the integrator down. `rd_neg` is later reported as the inverse of that value.
- R6: The comparator input passes through a two-flop synchroniser. The run-down ends on the first counting-clock edge at which the synchronised comparator differs from `ref_down`. The reading is the number of counts completed before that edge, in BCD: bits [3:0] units, [7:4] tens, [11:8] hundreds, [15:12] thousands.
- R7: If no crossing is seen by the DEI_MAX-th run-down count, the run-down ends there. The reading is then DEI_MAX in BCD and `rd_ovr`=1; otherwise `rd_ovr`=0.
- R8: `rd_valid` pulses for exactly one clock, in the cycle after the run-down ends. `rd_bcd`, `rd_neg` and `rd_ovr` change only together with that pulse.
- R9: After reset, the first null phase lasts AZ_BASE+DEI_MAX counts. From then on, integrate phases start every INT_CNT+DEI_MAX+AZ_BASE counts, whatever the run-down length.
- R10: A zero reading keeps its sign, so both a positive zero (`rd_neg`=0) and a negative zero (`rd_neg`=1) can be reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_i | input | 1 | Asynchronous comparator, 1 when the integrator is above zero |
| ph_az | output | 1 | Offset-null phase enable |
| ph_int | output | 1 | Signal-integrate phase enable |
| ph_dei | output | 1 | Reference run-down phase enable |
| ref_down | output | 1 | Reference sign select, 1 drives the integrator downward |
| rd_valid | output | 1 | One-cycle strobe for a new result |
| rd_bcd | output | 4*NDIG | BCD reading, units digit lowest |
| rd_neg | output | 1 | Input polarity of the reading, 1 = negative |
| rd_ovr | output | 1 | Run-down reached full scale without a crossing |

## Verification
A phase counter that went wrong would show within one cycle as a change in the spacing between `ph_int` rising edges. It would also show as an integrate window that is not INT_CNT·DIV clocks long. A wrong decade count or a lost synchroniser stage shifts the reading at the next strobe by one or more counts. The bench predicts each reading exactly from its own integrator model. A polarity latched at the wrong moment flips `rd_neg` and `ref_down`. The integrator then diverges, so the result is an overrange instead of a small reading.

// File: rtl/dsadc_pkg.sv
// Shared types for the dual-slope conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dsadc_pkg;

    // Measurement cycle phases, in the order they run
    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DEI = 2'd2
    } phase_e;

endpackage

// File: rtl/dsadc_prescale.sv
// Divides the oscillator clock into a one-clock counting tick every DIV clocks.
// Assumes: DIV >= 2; synchronous active-low reset.
module dsadc_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] div_q;

    // Free-running modulo-DIV divider
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == CW'(DIV - 1))
            div_q <= '0;
        else
            div_q <= div_q + CW'(1);
    end

    assign tick = (div_q == CW'(DIV - 1));
endmodule

// File: rtl/dsadc_sync.sv
// Multi-flop synchroniser for the asynchronous comparator input.
// Assumes: STAGES >= 2; output reset to 0.
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dsadc_bcd_cnt.sv
// Cascaded decade counter with NDIG digits. It also offers the value
// one count ahead (q_nxt), so a caller can capture the count that is
// just about to complete.
// Assumes: clr has priority over inc; digits stay 0..9.
module dsadc_bcd_cnt #(
    parameter int NDIG = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            inc,
    output logic [4*NDIG-1:0] q,
    output logic [4*NDIG-1:0] q_nxt
);
    logic [NDIG-1:0] carry;

    assign carry[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [3:0] dig;
        logic [3:0] dig_nxt;

        // Next digit value given the carry from lower digits
        always_comb begin
            if (!carry[g])
                dig_nxt = dig;
            else if (dig == 4'd9)
                dig_nxt = 4'd0;
            else
                dig_nxt = dig + 4'd1;
        end

        // Digit register
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                dig <= 4'd0;
            else if (inc)
                dig <= dig_nxt;
        end

        if (g < NDIG - 1) begin : g_carry
            assign carry[g+1] = carry[g] && (dig == 4'd9);
        end

        assign q[4*g +: 4]     = dig;
        assign q_nxt[4*g +: 4] = dig_nxt;
    end
endmodule

// File: rtl/dsadc_seq_ctl.sv
// Phase controller for the dual-slope cycle. On each counting tick it
// advances the phase counter and:
//   - ends the null phase after az_len counts;
//   - ends integration after INT_CNT counts and latches the polarity;
//   - ends run-down on a comparator crossing or at DEI_MAX counts.
// The unused run-down time is handed to the next null phase.
// Assumes: cmp_s is already synchronised; AZ_BASE >= 1; DEI_MAX >= 2.
module dsadc_seq_ctl
    import dsadc_pkg::*;
#(
    parameter int INT_CNT = 1000,
    parameter int DEI_MAX = 2000,
    parameter int AZ_BASE = 1000,
    parameter int NDIG    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmp_s,
    input  logic [4*NDIG-1:0] cnt_q,
    input  logic [4*NDIG-1:0] cnt_nxt,
    output phase_e            phase,
    output logic              ref_down,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              rd_valid,
    output logic [4*NDIG-1:0] rd_bcd,
    output logic              rd_neg,
    output logic              rd_ovr
);
    localparam int AZ_MAX  = AZ_BASE + DEI_MAX;
    localparam int LEN_MAX = (AZ_MAX > INT_CNT) ? AZ_MAX : INT_CNT;
    localparam int PW      = $clog2(LEN_MAX + 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] az_len;
    logic          crossed;
    logic          full;
    logic          in_dei;
    logic          stop;

    // Run-down termination conditions
    always_comb begin
        crossed = (cmp_s != ref_down);
        full    = (pcnt == PW'(DEI_MAX - 1));
        in_dei  = (phase == PH_DEI);
        stop    = tick && in_dei && (crossed || full);
        cnt_clr = tick && (phase == PH_INT) && (pcnt == PW'(INT_CNT - 1));
        cnt_inc = tick && in_dei && !crossed && !full;
    end

    // Phase sequencing, phase counter, polarity and null-phase length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_AZ;
            pcnt     <= '0;
            ref_down <= 1'b0;
            az_len   <= PW'(AZ_MAX);
        end else if (tick) begin
            unique case (phase)
                PH_AZ: begin
                    if (pcnt == az_len - PW'(1)) begin
                        phase <= PH_INT;
                        pcnt  <= '0;
                    end else begin
                        pcnt <= pcnt + PW'(1);
                    end
                end
                PH_INT: begin
                    if (pcnt == PW'(INT_CNT - 1)) begin
                        phase    <= PH_DEI;
                        pcnt     <= '0;
                        ref_down <= cmp_s;
                    end else begin
                        pcnt <= pcnt + PW'(1);
                    end
                end
                PH_DEI: begin
                    if (crossed || full) begin
                        phase  <= PH_AZ;
                        pcnt   <= '0;
                        az_len <= PW'(AZ_MAX) - (pcnt + PW'(1));
                    end else begin
                        pcnt <= pcnt + PW'(1);
                    end
                end
                default: begin
                    phase <= PH_AZ;
                    pcnt  <= '0;
                end
            endcase
        end
    end

    // Result capture and one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_bcd   <= '0;
            rd_neg   <= 1'b0;
            rd_ovr   <= 1'b0;
        end else begin
            rd_valid <= stop;
            if (stop) begin
                rd_bcd <= crossed ? cnt_q : cnt_nxt;
                rd_ovr <= !crossed;
                rd_neg <= !ref_down;
            end
        end
    end
endmodule

// File: rtl/dsadc_seq.sv
// Top of the dual-slope conversion sequencer. Joins the clock divider,
// the comparator synchroniser, the decade run-down counter and the
// phase controller, and decodes the phase into one-hot enables.
// Assumes: cmp_i is 1 while the integrator output is above zero.
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int DIV     = 4,
    parameter int INT_CNT = 1000,
    parameter int DEI_MAX = 2000,
    parameter int AZ_BASE = 1000,
    parameter int NDIG    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_i,
    output logic              ph_az,
    output logic              ph_int,
    output logic              ph_dei,
    output logic              ref_down,
    output logic              rd_valid,
    output logic [4*NDIG-1:0] rd_bcd,
    output logic              rd_neg,
    output logic              rd_ovr
);
    logic              tick;
    logic              cmp_s;
    logic              cnt_clr;
    logic              cnt_inc;
    logic [4*NDIG-1:0] cnt_q;
    logic [4*NDIG-1:0] cnt_nxt;
    phase_e            phase;

    dsadc_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    dsadc_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (cmp_i),
        .q    (cmp_s)
    );

    dsadc_bcd_cnt #(.NDIG(NDIG)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .q    (cnt_q),
        .q_nxt(cnt_nxt)
    );

    dsadc_seq_ctl #(
        .INT_CNT(INT_CNT),
        .DEI_MAX(DEI_MAX),
        .AZ_BASE(AZ_BASE),
        .NDIG   (NDIG)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cmp_s   (cmp_s),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .phase   (phase),
        .ref_down(ref_down),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .rd_valid(rd_valid),
        .rd_bcd  (rd_bcd),
        .rd_neg  (rd_neg),
        .rd_ovr  (rd_ovr)
    );

    // One-hot phase enables for the analog switches
    always_comb begin
        ph_az  = (phase == PH_AZ);
        ph_int = (phase == PH_INT);
        ph_dei = (phase == PH_DEI);
    end
endmodule

// File: rtl/dsadc_seq_chk.sv
// Assertion checker for dsadc_seq, attached with bind. Watches the
// phase enables, the internal counting tick and the result outputs.
// Assumes: reset is held low for at least two clocks.
module dsadc_seq_chk #(
    parameter int NDIG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              ph_az,
    input logic              ph_int,
    input logic              ph_dei,
    input logic              ref_down,
    input logic              rd_valid,
    input logic [4*NDIG-1:0] rd_bcd,
    input logic              rd_neg,
    input logic              rd_ovr
);
    assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ph_az, ph_int, ph_dei}) == 1);

    assert_int_after_az_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_int) |-> $past(ph_az));

    assert_dei_after_int_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_dei) |-> $past(ph_int));

    assert_phase_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ph_az) || $rose(ph_int) || $rose(ph_dei)) |-> $past(tick));

    assert_ref_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_dei && $past(ph_dei)) |-> $stable(ref_down));

    assert_strobe_ends_dei_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(ph_dei) && ph_az));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable({rd_bcd, rd_neg, rd_ovr}));

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assert_digit_decimal_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> (rd_bcd[4*g +: 4] <= 4'd9));
    end
endmodule

bind dsadc_seq dsadc_seq_chk #(.NDIG(NDIG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ph_az   (ph_az),
    .ph_int  (ph_int),
    .ph_dei  (ph_dei),
    .ref_down(ref_down),
    .rd_valid(rd_valid),
    .rd_bcd  (rd_bcd),
    .rd_neg  (rd_neg),
    .rd_ovr  (rd_ovr)
);

// File: tb/tb_dsadc_seq.sv
// Bench for dsadc_seq with shortened counts. An integrator model steps
// on falling edges: +vin per clock while integrating, -/+vref per clock
// during run-down, and cleared during the null phase.
module tb_dsadc_seq;
    localparam int INT_C  = 100;
    localparam int DEI_C  = 200;
    localparam int AZB_C  = 100;
    localparam int PERIOD = 4 * (INT_C + DEI_C + AZB_C);
    localparam int AZ0    = 4 * (AZB_C + DEI_C);
    localparam int NV     = 10;
    // vin, vref, expected count, expected negative, expected overrange
    localparam int VEC [NV][5] = '{
        '{  5,   10,  50, 0, 0},
        '{ -5,   10,  50, 1, 0},
        '{  7,    4, 175, 0, 0},
        '{ -3,    2, 150, 1, 0},
        '{  1, 1000,   0, 0, 0},
        '{  0,   10,   0, 1, 0},
        '{ 25,   10, 200, 0, 1},
        '{-30,   10, 200, 1, 1},
        '{199,  100, 199, 0, 0},
        '{  3,   10,  30, 0, 0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_i = 1'b0;
    logic        ph_az, ph_int, ph_dei, ref_down, rd_valid, rd_neg, rd_ovr;
    logic [15:0] rd_bcd;

    int     vin = 0;
    int     vref = 10;
    int     acc = 0;
    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;
    bit     done = 1'b0;

    dsadc_seq #(.DIV(4), .INT_CNT(INT_C), .DEI_MAX(DEI_C), .AZ_BASE(AZB_C), .NDIG(4)) dut (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i),
        .ph_az(ph_az), .ph_int(ph_int), .ph_dei(ph_dei), .ref_down(ref_down),
        .rd_valid(rd_valid), .rd_bcd(rd_bcd), .rd_neg(rd_neg), .rd_ovr(rd_ovr)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r = '0;
        int t = v;
        for (int d = 0; d < 4; d++) begin
            r[4*d +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk_reset_state(input string when);
        chk(ph_az && !ph_int && !ph_dei, "R1", {when, " phase"}, {ph_az, ph_int, ph_dei}, 3'b100);
        chk(!rd_valid && rd_bcd == 16'h0 && !rd_neg && !rd_ovr && !ref_down, "R1",
            {when, " outputs"}, {rd_valid, rd_bcd, rd_neg, rd_ovr, ref_down}, 0);
    endtask

    // Edge counter since reset release
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Analog integrator and comparator model
    always @(negedge clk) begin
        if (ph_az === 1'b1)       acc = 0;
        else if (ph_int === 1'b1) acc = acc + vin;
        else if (ph_dei === 1'b1) acc = ref_down ? acc - vref : acc + vref;
        cmp_i = (acc > 0);
    end

    // Phase timing and result-hold monitor
    bit          first_int = 1'b1;
    logic        p_int = 1'b0, p_dei = 1'b0;
    longint      t_int = 0, t_dei = 0;
    logic [17:0] p_res = '0;
    int          hold_bad = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            first_int = 1'b1;
            p_int = 1'b0;
            p_dei = 1'b0;
            p_res = {rd_bcd, rd_neg, rd_ovr};
        end else begin
            if (ph_int && !p_int) begin
                if (first_int) chk(cyc == AZ0, "R9", "first null length", cyc, AZ0);
                else           chk(cyc - t_int == PERIOD, "R9", "cycle period", cyc - t_int, PERIOD);
                first_int = 1'b0;
                t_int = cyc;
            end
            if (ph_dei && !p_dei) begin
                chk(cyc - t_int == 4 * INT_C, "R4", "integrate length", cyc - t_int, 4 * INT_C);
                t_dei = cyc;
            end
            if (!ph_dei && p_dei)
                chk((cyc - t_dei) % 4 == 0, "R3", "run-down on count edge", (cyc - t_dei) % 4, 0);
            if (!rd_valid && {rd_bcd, rd_neg, rd_ovr} != p_res) hold_bad++;
            p_int = ph_int;
            p_dei = ph_dei;
            p_res = {rd_bcd, rd_neg, rd_ovr};
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R6", "watchdog expired", 0, 1);
            finish_run();
        end
    end

    task automatic run_vec(input int vi, input int vr, input int e_cnt,
                           input int e_neg, input int e_ovr);
        vin  = vi;
        vref = vr;
        do @(negedge clk); while (!rd_valid);
        chk(rd_bcd == to_bcd(e_cnt), (e_ovr != 0) ? "R7" : "R6", "reading", rd_bcd, to_bcd(e_cnt));
        chk(rd_ovr == e_ovr[0], "R7", "overrange flag", rd_ovr, e_ovr);
        chk(rd_neg == e_neg[0], (e_cnt == 0) ? "R10" : "R5", "polarity", rd_neg, e_neg);
        chk(ref_down == !e_neg[0], "R5", "reference select", ref_down, !e_neg[0]);
        @(negedge clk);
        chk(!rd_valid, "R8", "strobe width", rd_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_reset_state("initial reset");
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++)
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);

        // Reset in the middle of a run-down
        vin = 9;
        vref = 10;
        do @(negedge clk); while (!ph_dei);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_reset_state("reset during run-down");
        rst_n = 1'b1;
        // First conversion after reset: 3*400 = 1200, n=120, stop tick 31, count 30
        run_vec(3, 10, 30, 0, 0);

        chk(hold_bad == 0, "R8", "result held between strobes", hold_bad, 0);
        done = 1'b1;
        finish_run();
    end
endmodule